// File: doc/BRIEF.md
# Inband Loopback Code Engine

This block sends and recognises the two repeating inband codes that ask a far-end T1 terminal to close or open a network loopback. On the transmit side, two control bits choose what goes out on each bit-rate tick. One bit selects a repeating `00001` (loop-up) sequence and the other selects a repeating `001` (loop-down) sequence. When neither is set, the normal payload bit passes through unchanged.

On the receive side, the recovered data stream is watched for each code. Each detector compares every incoming bit with the bit one code period earlier. It also checks that the most recent code-length window is a rotation of the code. Any tick that fails either test restarts a qualification counter. When the loop-up code has conformed for a full window of ticks (a parameter; five seconds at line rate is 7,720,000 ticks), a network-loopback flag is set. The flag is cleared by a full window of loop-down code or by a host remote-loopback command. A local-loop command suspends the loopback action without touching the flag. Every change of the flag latches an event bit that the host clears.

Top module: `loopcode_engine`

## Requirements
- R1: After reset, `loop_flag`, `loop_active` and `loop_event` are 0, and `tx_bit` equals `tx_payload`.
- R2: With `send_up`=1 and `send_dn`=0, `tx_bit` repeats 0,0,0,0,1. The sequence starts with the first 0 when the selection begins and advances by one position on each `bit_en` tick.
- R3: With `send_dn`=1, `tx_bit` repeats 0,0,1. The sequence starts with the first 0 when the selection begins and advances by one position on each `bit_en` tick.
- R4: When both `send_up` and `send_dn` are 1, the loop-down sequence is sent.
- R5: With neither send bit set, `tx_bit` equals `tx_payload` combinationally.
- R6: A `bit_en` tick conforms for a code of period P (P=5 for `00001`, P=3 for `001`) when two conditions hold. The bit must equal the bit received P ticks earlier, where bits before reset count as 0. The last P bits, this one included, must hold exactly one 1. `loop_flag` becomes 1 at the clock edge of the WINDOW-th consecutive conforming loop-up tick.
- R7: A non-conforming tick restarts the count, so the flag needs WINDOW further consecutive conforming ticks. After the count reaches WINDOW it holds until the next non-conforming tick.
- R8: `loop_flag` becomes 0 at the edge of the WINDOW-th consecutive conforming loop-down tick.
- R9: `remote_cmd`=1 clears `loop_flag` at the next edge, taking priority over a set in the same cycle.
- R10: While `local_loop`=1, `loop_active` is 0 and `loop_flag` keeps its value. Otherwise `loop_active` equals `loop_flag`.
- R11: `loop_event` becomes 1 at the edge where `loop_flag` changes. `evt_clear` clears it at an edge where the flag does not change, and a change wins over a clear.
- R12: With `bit_en`=0, neither the transmit sequence nor the receive counts advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Bit-rate tick enable |
| rx_bit | input | 1 | Recovered receive data bit |
| tx_payload | input | 1 | Normal transmit data bit |
| send_up | input | 1 | Request repeating loop-up code on transmit |
| send_dn | input | 1 | Request repeating loop-down code on transmit |
| remote_cmd | input | 1 | Host remote-loopback command, clears flag |
| local_loop | input | 1 | Local loop active, suspends network loopback |
| evt_clear | input | 1 | Host clear of the change event |
| tx_bit | output | 1 | Transmit data bit |
| loop_flag | output | 1 | Network loopback status flag |
| loop_active | output | 1 | Network loopback currently in effect |
| loop_event | output | 1 | Latched change of loop_flag |

## Verification
On every cycle, the assertions check several properties. The flag may only rise after a loop-up hit and may only fall after a loop-down hit or a remote command. A remote command always leaves the flag clear, and local loop forces the active output low. Any flag change leaves the event set, the payload passes through when no code is requested, and the two detectors never qualify together. Three things can only be shown by the bench's scenarios, using its reference model: the exact length of the qualification window, the restart after a single bit error, and the transmitted code sequences, including the priority of loop-down.

// File: rtl/lc_pkg.sv
package lc_pkg;
  localparam int LC_MAXLEN = 8;

  // True when the low len bits of win are a cyclic rotation of code.
  function automatic logic lc_is_rotation(logic [7:0] win, logic [7:0] code, int len);
    logic [7:0] mask;
    logic [7:0] rot;
    logic       hit;
    mask = 8'((16'd1 << len) - 16'd1);
    hit  = 1'b0;
    for (int r = 0; r < LC_MAXLEN; r++) begin
      if (r < len) begin
        rot = 8'(((code << r) | (code >> (len - r))) & mask);
        if ((win & mask) == rot) hit = 1'b1;
      end
    end
    return hit;
  endfunction

  // Bit sent at a given phase, most significant code bit first.
  function automatic logic lc_code_bit(logic [7:0] code, int len, logic [2:0] phase);
    return code[3'(len - 1 - int'(phase))];
  endfunction
endpackage

// File: rtl/lc_code_tx.sv
module lc_code_tx #(
  parameter int         LEN  = 5,
  parameter logic [7:0] CODE = 8'h01
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic sel,
  output logic bit_o
);
  import lc_pkg::*;
  localparam logic [2:0] LAST = 3'(LEN - 1);

  logic [2:0] phase;

  always_ff @(posedge clk) begin
    if (!rst_n)      phase <= '0;
    else if (!sel)   phase <= '0;
    else if (bit_en) phase <= (phase == LAST) ? 3'd0 : phase + 3'd1;
  end

  assign bit_o = lc_code_bit(CODE, LEN, phase);
endmodule

// File: rtl/lc_code_rx.sv
module lc_code_rx #(
  parameter int         LEN    = 5,
  parameter logic [7:0] CODE   = 8'h01,
  parameter int         WINDOW = 7720000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic rx_bit,
  output logic hit
);
  import lc_pkg::*;
  localparam int CW = $clog2(WINDOW + 1);
  localparam logic [CW-1:0] FULL = CW'(WINDOW);
  localparam logic [CW-1:0] NEAR = CW'(WINDOW - 1);

  logic [LEN-1:0] hist;
  logic [LEN-1:0] win;
  logic [CW-1:0]  cnt;
  logic           conform;

  assign win     = {hist[LEN-2:0], rx_bit};
  assign conform = (rx_bit == hist[LEN-1]) && lc_is_rotation(8'(win), CODE, LEN);
  assign hit     = bit_en && conform && (cnt == NEAR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist <= '0;
      cnt  <= '0;
    end else if (bit_en) begin
      hist <= win;
      if (!conform)          cnt <= '0;
      else if (cnt != FULL)  cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/lc_loop_state.sv
module lc_loop_state (
  input  logic clk,
  input  logic rst_n,
  input  logic up_hit,
  input  logic dn_hit,
  input  logic remote_cmd,
  input  logic local_loop,
  input  logic evt_clear,
  output logic flag,
  output logic active,
  output logic evt
);
  logic flag_next;

  always_comb begin
    flag_next = flag;
    if (remote_cmd || dn_hit) flag_next = 1'b0;
    else if (up_hit)          flag_next = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag <= 1'b0;
      evt  <= 1'b0;
    end else begin
      flag <= flag_next;
      if (flag_next != flag) evt <= 1'b1;
      else if (evt_clear)    evt <= 1'b0;
    end
  end

  assign active = flag && !local_loop;
endmodule

// File: rtl/loopcode_engine.sv
module loopcode_engine #(
  parameter int         WINDOW  = 7720000,
  parameter int         UP_LEN  = 5,
  parameter logic [7:0] UP_CODE = 8'b0000_0001,
  parameter int         DN_LEN  = 3,
  parameter logic [7:0] DN_CODE = 8'b0000_0001
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic rx_bit,
  input  logic tx_payload,
  input  logic send_up,
  input  logic send_dn,
  input  logic remote_cmd,
  input  logic local_loop,
  input  logic evt_clear,
  output logic tx_bit,
  output logic loop_flag,
  output logic loop_active,
  output logic loop_event
);
  localparam int         NCODE = 2;
  localparam int         LEN_T  [NCODE] = '{UP_LEN, DN_LEN};
  localparam logic [7:0] CODE_T [NCODE] = '{UP_CODE, DN_CODE};

  // index 0: loop-up, index 1: loop-down
  logic [NCODE-1:0] sel;
  logic [NCODE-1:0] gen_bit;
  logic [NCODE-1:0] hit;
  logic             up_hit_w;
  logic             dn_hit_w;

  assign sel[1] = send_dn;
  assign sel[0] = send_up && !send_dn;

  for (genvar g = 0; g < NCODE; g++) begin : g_code
    lc_code_tx #(.LEN(LEN_T[g]), .CODE(CODE_T[g])) u_tx (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .sel(sel[g]), .bit_o(gen_bit[g])
    );
    lc_code_rx #(.LEN(LEN_T[g]), .CODE(CODE_T[g]), .WINDOW(WINDOW)) u_rx (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit), .hit(hit[g])
    );
  end

  assign up_hit_w = hit[0];
  assign dn_hit_w = hit[1];

  assign tx_bit = sel[1] ? gen_bit[1] : (sel[0] ? gen_bit[0] : tx_payload);

  lc_loop_state u_state (
    .clk(clk), .rst_n(rst_n), .up_hit(up_hit_w), .dn_hit(dn_hit_w),
    .remote_cmd(remote_cmd), .local_loop(local_loop), .evt_clear(evt_clear),
    .flag(loop_flag), .active(loop_active), .evt(loop_event)
  );
endmodule

// File: rtl/lc_checker.sv
module lc_checker (
  input logic clk,
  input logic rst_n,
  input logic up_hit,
  input logic dn_hit,
  input logic remote_cmd,
  input logic local_loop,
  input logic send_up,
  input logic send_dn,
  input logic tx_payload,
  input logic tx_bit,
  input logic flag,
  input logic active,
  input logic evt
);
  // R6
  flag_rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(up_hit));
  // R8
  flag_fall_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> $past(dn_hit || remote_cmd));
  // R9
  remote_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    remote_cmd |=> !flag);
  // R10
  local_suspend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    local_loop |-> !active);
  // R10
  local_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (local_loop && !remote_cmd && !up_hit && !dn_hit) |=> $stable(flag));
  // R11
  event_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag != $past(flag)) |-> evt);
  // R5
  payload_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!send_up && !send_dn) |-> (tx_bit == tx_payload));
  // R7
  hit_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({up_hit, dn_hit}));
endmodule

bind loopcode_engine lc_checker u_lc_checker (
  .clk(clk), .rst_n(rst_n), .up_hit(up_hit_w), .dn_hit(dn_hit_w),
  .remote_cmd(remote_cmd), .local_loop(local_loop), .send_up(send_up),
  .send_dn(send_dn), .tx_payload(tx_payload), .tx_bit(tx_bit),
  .flag(loop_flag), .active(loop_active), .evt(loop_event)
);

// File: tb/test_loopcode_engine.sv
module test_loopcode_engine;
  localparam int CLK_PERIOD = 10;
  localparam int W = 20;
  localparam int WATCHDOG = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_en = 1'b0, rx_bit = 1'b0, tx_payload = 1'b0;
  logic send_up = 1'b0, send_dn = 1'b0, remote_cmd = 1'b0;
  logic local_loop = 1'b0, evt_clear = 1'b0;
  logic tx_bit, loop_flag, loop_active, loop_event;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  // behavioural reference state
  int q[$];
  int cnt_up = 0, cnt_dn = 0, ph_up = 0, ph_dn = 0;
  bit m_flag = 0, m_evt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  loopcode_engine #(.WINDOW(W)) i_loopcode_engine (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit),
    .tx_payload(tx_payload), .send_up(send_up), .send_dn(send_dn),
    .remote_cmd(remote_cmd), .local_loop(local_loop), .evt_clear(evt_clear),
    .tx_bit(tx_bit), .loop_flag(loop_flag), .loop_active(loop_active),
    .loop_event(loop_event)
  );

  task automatic chk(string tag, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b at time %0t", tag, got, exp, $time);
    end
  endtask

  function automatic bit periodic_ok(int p);
    int ones = 0;
    for (int k = 0; k < p; k++) ones += q[q.size() - 1 - k];
    return (q[q.size() - 1] == q[q.size() - 1 - p]) && (ones == 1);
  endfunction

  task automatic model_reset();
    q.delete();
    for (int k = 0; k < 8; k++) q.push_back(0);
    cnt_up = 0; cnt_dn = 0; ph_up = 0; ph_dn = 0; m_flag = 0; m_evt = 0;
  endtask

  // One clock: advance the model with the current inputs, then compare.
  task automatic cyc();
    bit uphit = 0, dnhit = 0, fn, sel_up, sel_dn, exp_tx;
    string ttag;
    if (bit_en) begin
      q.push_back(int'(rx_bit));
      if (q.size() > 16) void'(q.pop_front());
      if (periodic_ok(5)) begin
        uphit = (cnt_up == W - 1);
        if (cnt_up < W) cnt_up++;
      end else cnt_up = 0;
      if (periodic_ok(3)) begin
        dnhit = (cnt_dn == W - 1);
        if (cnt_dn < W) cnt_dn++;
      end else cnt_dn = 0;
    end
    fn = m_flag;
    if (remote_cmd || dnhit) fn = 0;
    else if (uphit) fn = 1;
    if (fn != m_flag) m_evt = 1;
    else if (evt_clear) m_evt = 0;
    m_flag = fn;
    sel_dn = send_dn;
    sel_up = send_up && !send_dn;
    ph_dn = !sel_dn ? 0 : (bit_en ? (ph_dn + 1) % 3 : ph_dn);
    ph_up = !sel_up ? 0 : (bit_en ? (ph_up + 1) % 5 : ph_up);
    @(posedge clk);
    #1;
    exp_tx = sel_dn ? (ph_dn == 2) : (sel_up ? (ph_up == 4) : tx_payload);
    if (!bit_en && (sel_dn || sel_up)) ttag = "R12 tx hold";
    else if (send_up && send_dn) ttag = "R4 tx priority";
    else if (sel_dn) ttag = "R3 tx loop-down";
    else if (sel_up) ttag = "R2 tx loop-up";
    else ttag = "R5 tx payload";
    chk(ttag, tx_bit, exp_tx);
    chk("R6 flag model", loop_flag, m_flag);
    chk("R10 active model", loop_active, m_flag && !local_loop);
    chk("R11 event model", loop_event, m_evt);
  endtask

  task automatic feed(int p, int n);
    int ph = 0;
    bit_en = 1'b1;
    for (int i = 0; i < n; i++) begin
      rx_bit = (ph == p - 1);
      ph = (ph + 1) % p;
      cyc();
    end
  endtask

  initial begin
    for (int i = 0; i < WATCHDOG; i++) begin
      @(posedge clk);
      cycles++;
    end
    fails++;
    $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    tx_payload = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    model_reset();
    // R1 reset state
    chk("R1 flag", loop_flag, 1'b0);
    chk("R1 event", loop_event, 1'b0);
    chk("R1 active", loop_active, 1'b0);
    chk("R1 tx", tx_bit, 1'b1);

    // transmit codes, with tick gaps
    bit_en = 1'b1; send_up = 1'b1;
    for (int i = 0; i < 12; i++) begin bit_en = (i % 4 != 3); cyc(); end
    send_up = 1'b0; send_dn = 1'b1;
    for (int i = 0; i < 10; i++) begin bit_en = (i % 3 != 1); cyc(); end
    send_up = 1'b1;
    for (int i = 0; i < 9; i++) begin bit_en = 1'b1; cyc(); end
    send_up = 1'b0; send_dn = 1'b0;
    for (int i = 0; i < 8; i++) begin tx_payload = i[0]; cyc(); end
    chk("R5 payload direct", tx_bit, tx_payload);

    // R7: one bit error restarts qualification
    feed(5, W - 2);
    bit_en = 1'b1; rx_bit = 1'b1; cyc();
    feed(5, W - 2);
    chk("R7 no flag after broken run", loop_flag, 1'b0);
    // R6: continuous loop-up sets flag
    feed(5, W + 10);
    chk("R6 flag set", loop_flag, 1'b1);
    chk("R11 event after set", loop_event, 1'b1);
    evt_clear = 1'b1; cyc(); evt_clear = 1'b0;
    chk("R11 event cleared", loop_event, 1'b0);

    // R10: local loop suspends without touching the flag
    local_loop = 1'b1; feed(3, 4);
    chk("R10 active low", loop_active, 1'b0);
    chk("R10 flag kept", loop_flag, 1'b1);
    local_loop = 1'b0; bit_en = 1'b0; cyc();
    chk("R10 active restored", loop_active, 1'b1);

    // R8: continuous loop-down clears flag
    feed(3, 2 * W + 3);
    chk("R8 flag cleared", loop_flag, 1'b0);
    chk("R11 event after clear", loop_event, 1'b1);
    evt_clear = 1'b1; cyc(); evt_clear = 1'b0;

    // R9: remote command clears flag
    feed(5, 2 * W + 8);
    chk("R9 precondition flag", loop_flag, 1'b1);
    remote_cmd = 1'b1; cyc(); remote_cmd = 1'b0;
    chk("R9 flag cleared by remote", loop_flag, 1'b0);
    feed(5, 10);
    chk("R9 flag stays clear", loop_flag, 1'b0);

    // R12: no ticks, no qualification
    rst_n = 1'b0; @(posedge clk); #1; rst_n = 1'b1; model_reset();
    bit_en = 1'b0;
    for (int i = 0; i < 3 * W; i++) begin rx_bit = (i % 5 == 4); cyc(); end
    chk("R12 no flag without ticks", loop_flag, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule